// File: doc/BRIEF.md
# Defect-Aware Segment Allocator

This block builds the placement table for a memory array whose cells may be defective. A defect map, from which cells on broken wires have already been removed, is read one cell per clock. The block walks the array from address 0 and carves it into segments. Each segment holds one coded block of `K_BITS` user bits followed by the check bits of an error-correcting code. For every segment it also picks the cheapest code from a table of eight. That code must correct every defective cell in the segment plus a fixed number of extra errors, which are held back for transient faults.

The choice of code and the placement of the segment are made together. A fresh segment starts `K_BITS` long and uses code 0, which has no check bits. When the defects found plus the margin exceed what the current code corrects, a stronger code is selected and the segment grows by that code's check bits. The new cells are then scanned and the segment is judged again. When no code in the table is strong enough, the segment is abandoned and the search restarts just past its first defective cell. Segment heads are rounded up to a multiple of `ALIGN`. For each accepted segment the block emits a record with the head address divided by `ALIGN` and the 3-bit code index. `done` rises when no further segment fits in the array.

Top module: `defect_seg_alloc`

## Requirements
- R1: After reset and before `start`, `rec_valid`, `done` and `map_rd_en` are all low.
- R2: The map is read through a synchronous port with one cycle of latency.
  - At most one cell is read per cycle, and every read address is below `N_CELLS`.
  - Reads in back-to-back cycles use consecutive addresses.
- R3: A new segment covers `K_BITS` cells from its head and starts with code 0. On a defect-free map with `margin` 0, every record carries code 0 and the heads are `K_BITS` apart.
- R4: A segment is accepted when the t of the current code is at least the number of defective cells in the segment plus `margin`.
- R5: If that sum is at most the largest t in the table, the lowest index whose t covers it is selected. The segment then grows to `K_BITS` plus that code's redundancy, the added cells are scanned, and the test of R4 is repeated.
- R6: If the sum exceeds the largest t in the table, the segment is dropped. The next head is the first defective cell of the segment plus one, rounded up to `ALIGN`.
- R7: After an accepted segment, the next head is the cell just after its last cell, rounded up to a multiple of `ALIGN`. Accepted heads strictly increase within a run.
- R8: A record gives `rec_head` = head / `ALIGN` and `rec_code` = the code index (0..7). `rec_valid` is high for exactly one cycle per record.
- R9: Allocation stops, with `done` raised, in any of these cases:
  - a new head plus `K_BITS` exceeds `N_CELLS`;
  - a grown segment would pass the end of the array;
  - the sum exceeds the largest t and the segment has no defect.
- R10: Code index i has t = i·`T_STEP` and redundancy i·`T_STEP`·`GF_M` check bits. With the defaults, t runs 0,2,…,14 and redundancy runs 0,8,…,56.
- R11: `done` stays high and no record or read occurs until the next `start`, which begins a new run from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run from cell 0 (accepted when idle or done) |
| margin | input | MARGIN_W | Errors reserved for transient faults; hold stable during a run |
| map_rd_en | output | 1 | Defect map read strobe |
| map_rd_addr | output | $clog2(N_CELLS) | Cell address being read |
| map_rd_defect | input | 1 | Defect flag of the cell read in the previous cycle |
| rec_valid | output | 1 | Record strobe |
| rec_head | output | $clog2(N_CELLS)-$clog2(ALIGN) | Segment head divided by ALIGN |
| rec_code | output | 3 | Selected code index |
| done | output | 1 | Allocation finished |

## Verification
The hardest path to reach is the relocation of R6. It needs a segment whose defects alone exceed the largest t, so it only occurs where defects cluster. The stimulus forces it with a directed run of sixteen adjacent defective cells. Random maps of rising density then mix relocation with multi-step growth, where a segment climbs through several codes before it is accepted. Every record is compared against a behavioural allocator in the bench that walks the same map.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int NCODES = 8;
    localparam int CIDX_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SCAN,
        ST_EVAL,
        ST_DONE
    } alloc_state_e;

    typedef struct packed {
        logic [CIDX_W-1:0] idx;
        logic              fits;
    } code_pick_t;

    // correctable errors of table entry idx
    function automatic int code_t(input int idx, input int step);
        return idx * step;
    endfunction

    // check bits of table entry idx
    function automatic int code_red(input int idx, input int step, input int m);
        return idx * step * m;
    endfunction

endpackage

// File: rtl/dsa_code_rom.sv
module dsa_code_rom
    import dsa_pkg::*;
#(
    parameter int PW     = 16,
    parameter int T_STEP = 2,
    parameter int GF_M   = 4
) (
    input  logic [PW-1:0] need,
    output code_pick_t    pick,
    output logic [PW-1:0] pick_t,
    output logic [PW-1:0] pick_red
);

    logic [NCODES-1:0] covers;
    logic [PW-1:0]     t_tab   [NCODES];
    logic [PW-1:0]     red_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_entry
        assign t_tab[g]   = PW'(code_t(g, T_STEP));
        assign red_tab[g] = PW'(code_red(g, T_STEP, GF_M));
        assign covers[g]  = (need <= t_tab[g]);
    end

    // lowest covering entry = least redundancy (table ascends in t)
    always_comb begin
        pick.fits = covers[NCODES-1];
        pick.idx  = '0;
        for (int i = NCODES - 1; i >= 0; i--) begin
            if (covers[i]) pick.idx = CIDX_W'(i);
        end
        pick_t   = t_tab[pick.idx];
        pick_red = red_tab[pick.idx];
    end

endmodule

// File: rtl/dsa_cell_scan.sv
module dsa_cell_scan #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          fire,
    input  logic [PW-1:0] addr,
    input  logic          defect,
    output logic          pend,
    output logic [PW-1:0] dcnt,
    output logic [PW-1:0] first_pos,
    output logic          first_vld
);

    logic [PW-1:0] pend_addr;

    // read data returns one cycle after fire; pend marks it
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend      <= 1'b0;
            pend_addr <= '0;
            dcnt      <= '0;
            first_pos <= '0;
            first_vld <= 1'b0;
        end else begin
            pend      <= fire;
            pend_addr <= addr;
            if (pend && defect) begin
                dcnt <= dcnt + 1'b1;
                if (!first_vld) begin
                    first_vld <= 1'b1;
                    first_pos <= pend_addr;
                end
            end
        end
    end

endmodule

// File: rtl/defect_seg_alloc.sv
module defect_seg_alloc
    import dsa_pkg::*;
#(
    parameter int N_CELLS  = 1024,
    parameter int K_BITS   = 32,
    parameter int ALIGN    = 8,
    parameter int T_STEP   = 2,
    parameter int GF_M     = 4,
    parameter int MARGIN_W = 4,
    localparam int AW      = $clog2(N_CELLS),
    localparam int AL_W    = $clog2(ALIGN),
    localparam int HW      = AW - AL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MARGIN_W-1:0] margin,
    output logic                map_rd_en,
    output logic [AW-1:0]       map_rd_addr,
    input  logic                map_rd_defect,
    output logic                rec_valid,
    output logic [HW-1:0]       rec_head,
    output logic [2:0]          rec_code,
    output logic                done
);

    localparam int RED_MAX = code_red(NCODES - 1, T_STEP, GF_M);
    localparam int PW = $clog2(2 * N_CELLS + ALIGN + K_BITS + RED_MAX + (1 << MARGIN_W)) + 1;
    localparam logic [PW-1:0] N_P   = PW'(N_CELLS);
    localparam logic [PW-1:0] K_P   = PW'(K_BITS);
    localparam logic [PW-1:0] AMASK = PW'(ALIGN - 1);

    alloc_state_e      state;
    logic [PW-1:0]     head, tail, seg_end, t_sel;
    logic [CIDX_W-1:0] code_sel;

    logic              fire, scan_clr, pend, first_vld;
    logic [PW-1:0]     dcnt, first_pos, need, pick_t, pick_red, grow_end;
    code_pick_t        pick;

    function automatic logic [PW-1:0] align_up(input logic [PW-1:0] x);
        return (x + AMASK) & ~AMASK;
    endfunction

    assign fire        = (state == ST_SCAN) && (tail < seg_end);
    assign scan_clr    = (state == ST_INIT);
    assign need        = dcnt + PW'(margin);
    assign grow_end    = head + K_P + pick_red;
    assign map_rd_en   = fire;
    assign map_rd_addr = tail[AW-1:0];
    assign done        = (state == ST_DONE);

    dsa_cell_scan #(.PW(PW)) scan_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (scan_clr),
        .fire      (fire),
        .addr      (tail),
        .defect    (map_rd_defect),
        .pend      (pend),
        .dcnt      (dcnt),
        .first_pos (first_pos),
        .first_vld (first_vld)
    );

    dsa_code_rom #(.PW(PW), .T_STEP(T_STEP), .GF_M(GF_M)) rom_i (
        .need     (need),
        .pick     (pick),
        .pick_t   (pick_t),
        .pick_red (pick_red)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            head      <= '0;
            tail      <= '0;
            seg_end   <= '0;
            t_sel     <= '0;
            code_sel  <= '0;
            rec_valid <= 1'b0;
            rec_head  <= '0;
            rec_code  <= '0;
        end else begin
            rec_valid <= 1'b0;
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        head  <= '0;
                        state <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    if (head + K_P > N_P) begin
                        state <= ST_DONE;
                    end else begin
                        tail     <= head;
                        seg_end  <= head + K_P;
                        t_sel    <= '0;
                        code_sel <= '0;
                        state    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (fire) tail <= tail + 1'b1;
                    else if (!pend) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (t_sel >= need) begin
                        rec_valid <= 1'b1;
                        rec_head  <= head[AW-1:AL_W];
                        rec_code  <= code_sel;
                        head      <= align_up(tail);
                        state     <= ST_INIT;
                    end else if (pick.fits) begin
                        if (grow_end > N_P) begin
                            state <= ST_DONE;
                        end else begin
                            seg_end  <= grow_end;
                            t_sel    <= pick_t;
                            code_sel <= pick.idx;
                            state    <= ST_SCAN;
                        end
                    end else if (first_vld) begin
                        head  <= align_up(first_pos + 1'b1);
                        state <= ST_INIT;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
    parameter int N_CELLS = 1024,
    parameter int AW      = 10,
    parameter int HW      = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          map_rd_en,
    input logic [AW-1:0] map_rd_addr,
    input logic          rec_valid,
    input logic [HW-1:0] rec_head,
    input logic          done
);

    logic [HW-1:0] last_head;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            seen      <= 1'b0;
            last_head <= '0;
        end else if (rec_valid) begin
            seen      <= 1'b1;
            last_head <= rec_head;
        end
    end

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!rec_valid && !map_rd_en && !done));

    // R2
    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        map_rd_en |-> (int'(map_rd_addr) < N_CELLS));

    // R2
    a_r2_consecutive_reads: assert property (@(posedge clk) disable iff (rst)
        (map_rd_en && $past(map_rd_en)) |-> (map_rd_addr == $past(map_rd_addr) + 1'b1));

    // R8
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

    // R7
    a_r7_heads_increase: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && seen) |-> (rec_head > last_head));

    // R11
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rec_valid && !map_rd_en));

    // R11
    a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

endmodule

bind defect_seg_alloc dsa_checker #(.N_CELLS(N_CELLS), .AW(AW), .HW(HW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .map_rd_en   (map_rd_en),
    .map_rd_addr (map_rd_addr),
    .rec_valid   (rec_valid),
    .rec_head    (rec_head),
    .done        (done)
);

// File: tb/defect_seg_alloc_tb_top.sv
module defect_seg_alloc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 1024;
    localparam int K   = 32;
    localparam int AL  = 8;
    localparam int TS  = 2;
    localparam int GM  = 4;
    localparam int MW  = 4;
    localparam int AW  = $clog2(N);
    localparam int HW  = AW - $clog2(AL);
    localparam int MAXR = 64;
    localparam int TMAX = 7 * TS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [MW-1:0] margin = '0;
    logic          map_rd_en;
    logic [AW-1:0] map_rd_addr;
    logic          map_rd_defect = 1'b0;
    logic          rec_valid;
    logic [HW-1:0] rec_head;
    logic [2:0]    rec_code;
    logic          done;

    bit defmap [N];
    int got_head [MAXR];
    int got_code [MAXR];
    int got_n = 0;
    int exp_head [MAXR];
    int exp_code [MAXR];
    int exp_n;
    int bad_reads = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic          prev_en = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    defect_seg_alloc #(
        .N_CELLS(N), .K_BITS(K), .ALIGN(AL), .T_STEP(TS), .GF_M(GM), .MARGIN_W(MW)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .margin        (margin),
        .map_rd_en     (map_rd_en),
        .map_rd_addr   (map_rd_addr),
        .map_rd_defect (map_rd_defect),
        .rec_valid     (rec_valid),
        .rec_head      (rec_head),
        .rec_code      (rec_code),
        .done          (done)
    );

    // synchronous map memory, one cycle latency
    always @(posedge clk) begin
        if (map_rd_en) map_rd_defect <= defmap[map_rd_addr];
        cyc <= cyc + 1;
    end

    // collector and read-pattern monitor
    always @(negedge clk) begin
        if (!rst && rec_valid) begin
            if (got_n < MAXR) begin
                got_head[got_n] = int'(rec_head);
                got_code[got_n] = int'(rec_code);
            end
            got_n = got_n + 1;
        end
        if (!rst && map_rd_en && prev_en && map_rd_addr != prev_addr + 1'b1)
            bad_reads = bad_reads + 1;
        prev_en   = map_rd_en;
        prev_addr = map_rd_addr;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int alup(input int x);
        return ((x + AL - 1) / AL) * AL;
    endfunction

    // behavioural allocator
    task automatic model(input int mg);
        int head = 0;
        bit stop = 0;
        exp_n = 0;
        while (!stop && head + K <= N) begin
            int len = K, tsel = 0, code = 0;
            bit seg_over = 0;
            while (!seg_over && !stop) begin
                int cnt = 0, first = -1, need;
                for (int a = head; a < head + len; a++)
                    if (defmap[a]) begin
                        if (first < 0) first = a;
                        cnt++;
                    end
                need = cnt + mg;
                if (tsel >= need) begin
                    if (exp_n < MAXR) begin
                        exp_head[exp_n] = head / AL;
                        exp_code[exp_n] = code;
                    end
                    exp_n++;
                    head = alup(head + len);
                    seg_over = 1;
                end else if (need <= TMAX) begin
                    int i = (need + TS - 1) / TS;
                    len = K + i * TS * GM;
                    if (head + len > N) stop = 1;
                    tsel = i * TS;
                    code = i;
                end else if (first >= 0) begin
                    head = alup(first + 1);
                    seg_over = 1;
                end else begin
                    stop = 1;
                end
            end
        end
    endtask

    task automatic run(input int mg, input string tag);
        int base;
        int limit;
        margin = MW'(mg);
        model(mg);
        @(negedge clk);
        base = got_n;
        bad_reads = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        limit = 0;
        while (!done && limit < 60000) begin
            @(negedge clk);
            limit++;
        end
        check(done == 1'b1, {tag, " R9 done"}, int'(done), 1);
        check(got_n - base == exp_n, {tag, " R9 record count"}, got_n - base, exp_n);
        for (int r = 0; r < exp_n && r < MAXR && base + r < MAXR; r++) begin
            check(got_head[base + r] == exp_head[r], {tag, " R7 head"}, got_head[base + r], exp_head[r]);
            check(got_code[base + r] == exp_code[r], {tag, " R5 code"}, got_code[base + r], exp_code[r]);
        end
        check(bad_reads == 0, {tag, " R2 read order"}, bad_reads, 0);
        repeat (4) @(negedge clk);
        check(done && !rec_valid && !map_rd_en, {tag, " R11 done held"}, int'(done), 1);
        got_n = 0;
    endtask

    initial begin
        int i0;
        void'($urandom(32'd20411));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rec_valid == 1'b0, "R1 rec_valid", int'(rec_valid), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(map_rd_en == 1'b0, "R1 read", int'(map_rd_en), 0);

        // R3: clean map, margin 0
        for (int a = 0; a < N; a++) defmap[a] = 0;
        run(0, "R3 clean");
        // R10 R5: clean map, margin 3 -> code 2 (t=4, 16 check bits)
        run(3, "R10 margin3");
        // R4: margin at largest t
        run(TMAX, "R4 margin14");
        // R9: margin above largest t
        run(TMAX + 1, "R9 margin15");
        // R6: dense cluster of 16 defects
        for (int a = 40; a < 56; a++) defmap[a] = 1;
        run(0, "R6 cluster");
        // random maps of increasing density
        for (int d = 1; d <= 6; d++) begin
            for (int a = 0; a < N; a++) defmap[a] = ($urandom_range(99) < 2 * d);
            i0 = $urandom_range(4);
            run(i0, "R5 random");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule